// File: doc/BRIEF.md
# Buffered SPI Command Sequencer

This block is an SPI master whose transfers are set up in memory rather than in registers. Software fills a shared byte buffer. The first two bytes hold a 16-bit header, stored most significant byte first. Any outgoing payload starts at byte offset 2. Software then writes a start code to the command register. The engine reads the header, checks it and clocks the requested bytes on the serial lanes. Received bytes land back in the buffer from offset 0 upward, and a completion flag is raised in a write-one-to-clear interrupt register.

The serial bit rate comes from the `sclkEn` pulse input. Each enabled cycle advances the serial clock by half a period. A per-profile mode register can switch read-only or write-only transfers to two data lanes. The command word names both a profile and a slave-select index for the transfer.

Top module: `pp_spi_engine`

## Requirements
- R1: After reset the status busy bit (bit 1 of register 1) is 0, `irq`, `spiSclk` and `spiSsActive` are low, and the raw interrupt register (register 2) reads 0.
- R2: Writing a command word whose low nibble is 1 while idle starts a transfer. Bits 15:12 of the word appear on `spiSsIdx` for the whole frame, and bits 10:8 pick the profile. Busy reads 1 until completion. `spiSsActive` is high only while data is clocked, and `spiSclk` only rises inside that frame.
- R3: The header holds the opcode in bits 15:13, the dual flag in bit 11 and the byte count in bits 9:0. Header opcode 2 sends the count bytes from buffer offset 2 upward, MSB first on lane 0. Each bit takes two `sclkEn` pulses: the first raises `spiSclk` and the second lowers it, so `spiSclk` only rises in a cycle following a `sclkEn` pulse.
- R4: Opcode 3 samples `spiDin[1]` on each rising `spiSclk`, MSB first, and stores byte k at buffer offset k.
- R5: Opcode 1 sends from offset 2+k and stores the received byte at offset k in the same frame.
- R6: When header bit 11 is set and the profile field is 1, two bits move per `spiSclk` period, with the higher bit on lane 1. The field is bits 17:16 of register 8+profile for opcode 3, and bits 19:18 for opcode 2. Otherwise the transfer uses one lane.
- R7: Completion sets raw bit 0. Register 4 reads raw AND mask (register 3), and `irq` is high exactly when that value is nonzero.
- R8: Writing ones to register 2 clears those raw bits.
- R9: A bad header sets raw bits 4 and 0 and completes without asserting `spiSsActive` or toggling `spiSclk`. A header is bad when its opcode is 5 to 7, or when a data opcode has a count of 0 or above its limit (512 for opcode 3, 510 otherwise).
- R10: Opcode 0 waits for count `sclkEn` pulses and opcode 4 completes at once. Both set raw bit 0 with no bus activity.
- R11: Command codes 3 and 4 abort a running transfer. Slave select and clock drop, busy clears and no completion bit is set. A start written while busy is ignored.
- R12: Command codes 0 and 2 have no effect: the engine stays idle and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 11 | Bit 10 set: buffer byte at bits 8:0; clear: register at bits 3:0 |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data (buffer uses bits 7:0) |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| sclkEn | input | 1 | Half-period advance pulse from the clock generator |
| spiSclk | output | 1 | Serial clock, idle low |
| spiSsActive | output | 1 | Slave select asserted |
| spiSsIdx | output | 4 | Index of the selected slave |
| spiDout | output | 2 | Outgoing data lanes |
| spiDin | input | 2 | Incoming data lanes (lane 1 in single mode) |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume `sclkEn` is a level sampled per core cycle, and that `spiDin` is settled during the low phase of `spiSclk`. They also assume software leaves the buffer alone while busy and names a profile below the profile count. The bench slave therefore changes `spiDin` only just after a falling serial clock or the start of a frame. The bench writes the buffer only while the engine is idle and uses profiles 0 and 2. One scenario gates `sclkEn` to every third cycle to check that pacing follows the pulse train rather than the core clock.

// File: rtl/pp_spi_pkg.sv
package pp_spi_pkg;
  localparam int HDR_BYTES = 2;

  localparam logic [2:0] OP_SLEEP = 3'd0;
  localparam logic [2:0] OP_XCHG  = 3'd1;
  localparam logic [2:0] OP_SEND  = 3'd2;
  localparam logic [2:0] OP_RECV  = 3'd3;
  localparam logic [2:0] OP_IRQ   = 3'd4;

  localparam logic [3:0] CMD_NOOP  = 4'd0;
  localparam logic [3:0] CMD_START = 4'd1;
  localparam logic [3:0] CMD_TRIG  = 4'd2;
  localparam logic [3:0] CMD_HALT  = 4'd3;
  localparam logic [3:0] CMD_FLUSH = 4'd4;

  localparam logic [3:0] REG_CMD     = 4'd0;
  localparam logic [3:0] REG_STATUS  = 4'd1;
  localparam logic [3:0] REG_INT_RAW = 4'd2;
  localparam logic [3:0] REG_INT_MSK = 4'd3;
  localparam logic [3:0] REG_INT_OUT = 4'd4;

  localparam int INT_W      = 5;
  localparam int INT_DONE   = 0;
  localparam int INT_BADCTL = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_XFER, ST_SLEEP} engState_t;

  typedef struct packed {
    logic sclkRise;
    logic sclkFall;
    logic loadTx;
    logic storeRx;
    logic abort;
    logic dual;
    logic txEn;
    logic rxEn;
  } ppStrobe_t;
endpackage

// File: rtl/pp_spi_dp.sv
module pp_spi_dp
  import pp_spi_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ppStrobe_t     stb,
  input  logic [AW-1:0] txAddr,
  input  logic [AW-1:0] rxAddr,
  input  logic          bufWe,
  input  logic [AW-1:0] bufAddr,
  input  logic [7:0]    bufWrByte,
  output logic [7:0]    bufRdByte,
  output logic [15:0]   hdrWord,
  input  logic [1:0]    spiDin,
  output logic          spiSclk,
  output logic [1:0]    spiDout
);
  logic [7:0] mem [BUF_BYTES];
  logic [7:0] txShift;
  logic [7:0] rxShift;

  // Bus writes are placed last so they win over a same-address receive store.
  always_ff @(posedge clk) begin
    if (stb.storeRx && stb.rxEn) mem[rxAddr] <= rxShift;
    if (bufWe) mem[bufAddr] <= bufWrByte;
  end

  assign hdrWord   = {mem[0], mem[1]};
  assign bufRdByte = mem[bufAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spiSclk <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
    end else if (stb.abort) begin
      spiSclk <= 1'b0;
      txShift <= '0;
    end else begin
      if (stb.sclkRise) begin
        spiSclk <= 1'b1;
        rxShift <= stb.dual ? {rxShift[5:0], spiDin} : {rxShift[6:0], spiDin[1]};
      end
      if (stb.sclkFall) spiSclk <= 1'b0;
      if (stb.loadTx) txShift <= stb.txEn ? mem[txAddr] : 8'h00;
      else if (stb.sclkFall) txShift <= stb.dual ? {txShift[5:0], 2'b00} : {txShift[6:0], 1'b0};
    end
  end

  assign spiDout = stb.dual ? txShift[7:6] : {1'b0, txShift[7]};
endmodule

// File: rtl/pp_spi_ctl.sv
module pp_spi_ctl
  import pp_spi_pkg::*;
#(
  parameter int BUF_BYTES    = 512,
  parameter int NUM_PROFILES = 8,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [3:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [15:0]      hdrWord,
  input  logic             sclkEn,
  output ppStrobe_t        stb,
  output logic [AW-1:0]    txAddr,
  output logic [AW-1:0]    rxAddr,
  output logic             ssActive,
  output logic [3:0]       ssIdx,
  output logic             busy,
  output logic [INT_W-1:0] intRaw,
  output logic             irq
);
  localparam int CW = AW + 1;
  localparam int PW = (NUM_PROFILES > 1) ? $clog2(NUM_PROFILES) : 1;
  localparam logic [CW-1:0] MAX_RECV = CW'(BUF_BYTES);
  localparam logic [CW-1:0] MAX_SEND = CW'(BUF_BYTES - HDR_BYTES);

  engState_t state;
  logic [CW-1:0] byteIdx, lastIdx, sleepCnt;
  logic [3:0] bitCnt;
  logic phase, dualQ, txEnQ, rxEnQ;
  logic [PW-1:0] profQ;
  logic [1:0] modeRd [NUM_PROFILES];
  logic [1:0] modeWr [NUM_PROFILES];
  logic [INT_W-1:0] intMask;
  logic [15:0] cmdShadow;

  logic cmdWr, abort, startOk, isData, hdrBad, dualSel, hdrGo;
  logic byteEnd, lastByte, xferTick, finishXfer, sleepDone, hdrDone;
  logic [3:0] cmdCode, step;
  logic [2:0] hdrOp;
  logic [CW-1:0] hdrCnt, cntLimit;
  logic [PW-1:0] modeIdx;
  logic [INT_W-1:0] intSet, intClr;
  logic unusedHdr;

  assign unusedHdr = ^hdrWord;

  assign cmdWr   = regWrEn && (regAddr == REG_CMD);
  assign cmdCode = regWrData[3:0];
  assign abort   = cmdWr && (cmdCode == CMD_HALT || cmdCode == CMD_FLUSH) && (state != ST_IDLE);
  assign startOk = cmdWr && (cmdCode == CMD_START) && (state == ST_IDLE);

  assign hdrOp    = hdrWord[15:13];
  assign hdrCnt   = hdrWord[CW-1:0];
  assign isData   = (hdrOp == OP_XCHG) || (hdrOp == OP_SEND) || (hdrOp == OP_RECV);
  assign cntLimit = (hdrOp == OP_RECV) ? MAX_RECV : MAX_SEND;
  assign hdrBad   = (hdrOp > OP_IRQ) || (isData && (hdrCnt == '0 || hdrCnt > cntLimit));
  assign dualSel  = hdrWord[11] &&
                    (((hdrOp == OP_RECV) && (modeRd[profQ] == 2'd1)) ||
                     ((hdrOp == OP_SEND) && (modeWr[profQ] == 2'd1)));
  assign hdrGo    = (state == ST_HDR) && !abort && !hdrBad && isData;
  assign hdrDone  = (state == ST_HDR) && !abort && (hdrBad || hdrOp == OP_IRQ);

  assign step       = dualQ ? 4'd2 : 4'd1;
  assign byteEnd    = (bitCnt + step) == 4'd8;
  assign lastByte   = (byteIdx == lastIdx);
  assign xferTick   = (state == ST_XFER) && sclkEn && !abort;
  assign finishXfer = xferTick && phase && byteEnd && lastByte;
  assign sleepDone  = (state == ST_SLEEP) && (sleepCnt == '0) && !abort;

  always_comb begin
    intSet = '0;
    intSet[INT_DONE]   = hdrDone || finishXfer || sleepDone;
    intSet[INT_BADCTL] = (state == ST_HDR) && !abort && hdrBad;
    intClr = (regWrEn && regAddr == REG_INT_RAW) ? regWrData[INT_W-1:0] : '0;
  end

  always_comb begin
    stb          = '0;
    stb.abort    = abort;
    stb.dual     = (state == ST_HDR) ? dualSel : dualQ;
    stb.txEn     = (state == ST_HDR) ? (hdrOp == OP_XCHG || hdrOp == OP_SEND) : txEnQ;
    stb.rxEn     = rxEnQ;
    stb.sclkRise = xferTick && !phase;
    stb.sclkFall = xferTick && phase;
    stb.storeRx  = xferTick && phase && byteEnd;
    stb.loadTx   = hdrGo || (xferTick && phase && byteEnd && !lastByte);
    txAddr = (state == ST_HDR) ? AW'(HDR_BYTES) : AW'(byteIdx + CW'(HDR_BYTES) + CW'(1));
    rxAddr = AW'(byteIdx);
  end

  assign busy    = (state != ST_IDLE);
  assign irq     = |(intRaw & intMask);
  assign modeIdx = regAddr[PW-1:0];

  always_comb begin
    case (regAddr)
      REG_CMD:     regRdData = {16'h0, cmdShadow};
      REG_STATUS:  regRdData = {30'h0, busy, 1'b0};
      REG_INT_RAW: regRdData = 32'(intRaw);
      REG_INT_MSK: regRdData = 32'(intMask);
      REG_INT_OUT: regRdData = 32'(intRaw & intMask);
      default:
        if (regAddr[3] && int'(modeIdx) < NUM_PROFILES)
          regRdData = {12'h0, modeWr[modeIdx], modeRd[modeIdx], 16'h0};
        else
          regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intRaw    <= '0;
      intMask   <= '0;
      cmdShadow <= '0;
      for (int i = 0; i < NUM_PROFILES; i++) begin
        modeRd[i] <= '0;
        modeWr[i] <= '0;
      end
    end else begin
      intRaw <= (intRaw & ~intClr) | intSet;
      if (regWrEn && regAddr == REG_INT_MSK) intMask <= regWrData[INT_W-1:0];
      if (cmdWr) cmdShadow <= regWrData[15:0];
      if (regWrEn && regAddr[3] && int'(modeIdx) < NUM_PROFILES) begin
        modeRd[modeIdx] <= regWrData[17:16];
        modeWr[modeIdx] <= regWrData[19:18];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteIdx  <= '0;
      lastIdx  <= '0;
      sleepCnt <= '0;
      bitCnt   <= '0;
      phase    <= 1'b0;
      dualQ    <= 1'b0;
      txEnQ    <= 1'b0;
      rxEnQ    <= 1'b0;
      profQ    <= '0;
      ssActive <= 1'b0;
      ssIdx    <= '0;
    end else if (abort) begin
      state    <= ST_IDLE;
      ssActive <= 1'b0;
      phase    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startOk) begin
          state <= ST_HDR;
          ssIdx <= regWrData[15:12];
          profQ <= regWrData[PW+7:8];
        end
        ST_HDR: begin
          if (hdrBad || hdrOp == OP_IRQ) state <= ST_IDLE;
          else if (hdrOp == OP_SLEEP) begin
            state    <= ST_SLEEP;
            sleepCnt <= hdrCnt;
          end else begin
            state    <= ST_XFER;
            byteIdx  <= '0;
            lastIdx  <= hdrCnt - CW'(1);
            bitCnt   <= '0;
            phase    <= 1'b0;
            dualQ    <= dualSel;
            txEnQ    <= (hdrOp != OP_RECV);
            rxEnQ    <= (hdrOp != OP_SEND);
            ssActive <= 1'b1;
          end
        end
        ST_XFER: if (sclkEn) begin
          phase <= ~phase;
          if (phase) begin
            if (byteEnd) begin
              bitCnt <= '0;
              if (lastByte) begin
                state    <= ST_IDLE;
                ssActive <= 1'b0;
              end else byteIdx <= byteIdx + CW'(1);
            end else bitCnt <= bitCnt + step;
          end
        end
        ST_SLEEP: begin
          if (sleepCnt == '0) state <= ST_IDLE;
          else if (sclkEn) sleepCnt <= sleepCnt - CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_spi_engine.sv
module pp_spi_engine
  import pp_spi_pkg::*;
#(
  parameter int BUF_BYTES    = 512,
  parameter int NUM_PROFILES = 8,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [AW+1:0] busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        sclkEn,
  output logic        spiSclk,
  output logic        spiSsActive,
  output logic [3:0]  spiSsIdx,
  output logic [1:0]  spiDout,
  input  logic [1:0]  spiDin,
  output logic        irq
);
  ppStrobe_t stb;
  logic [AW-1:0] txAddr, rxAddr;
  logic [15:0] hdrWord;
  logic [7:0] bufRdByte;
  logic [31:0] regRdData;
  logic bufSel, busy;
  logic [INT_W-1:0] intRaw;
  logic unusedAddr;

  assign bufSel     = busAddr[AW+1];
  assign unusedAddr = busAddr[AW];
  assign busRdData  = bufSel ? {24'h0, bufRdByte} : regRdData;

  pp_spi_ctl #(.BUF_BYTES(BUF_BYTES), .NUM_PROFILES(NUM_PROFILES)) u_ctl (
    .clk(clk), .rstN(rstN),
    .regWrEn(busWrEn && !bufSel), .regAddr(busAddr[3:0]), .regWrData(busWrData),
    .regRdData(regRdData), .hdrWord(hdrWord), .sclkEn(sclkEn), .stb(stb),
    .txAddr(txAddr), .rxAddr(rxAddr), .ssActive(spiSsActive), .ssIdx(spiSsIdx),
    .busy(busy), .intRaw(intRaw), .irq(irq)
  );

  pp_spi_dp #(.BUF_BYTES(BUF_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txAddr(txAddr), .rxAddr(rxAddr),
    .bufWe(busWrEn && bufSel), .bufAddr(busAddr[AW-1:0]), .bufWrByte(busWrData[7:0]),
    .bufRdByte(bufRdByte), .hdrWord(hdrWord), .spiDin(spiDin),
    .spiSclk(spiSclk), .spiDout(spiDout)
  );
endmodule

// File: rtl/pp_spi_engine_chk.sv
module pp_spi_engine_chk
  import pp_spi_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sclkEn,
  input logic             spiSclk,
  input logic             spiSsActive,
  input logic [3:0]       spiSsIdx,
  input logic             busy,
  input logic [INT_W-1:0] intRaw
);
  assert_frame_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    spiSsActive |-> busy);
  assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> spiSsActive);
  assert_ss_idx_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (spiSsActive && $past(spiSsActive)) |-> $stable(spiSsIdx));
  assert_sclk_paced_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSclk) |-> $past(sclkEn));
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intRaw[INT_DONE]) |-> $past(busy));
  assert_bad_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intRaw[INT_BADCTL]) |-> (!spiSsActive && !spiSclk));
  assert_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!spiSsActive && !spiSclk));
endmodule

bind pp_spi_engine pp_spi_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .sclkEn(sclkEn), .spiSclk(spiSclk),
  .spiSsActive(spiSsActive), .spiSsIdx(spiSsIdx), .busy(busy), .intRaw(intRaw)
);

// File: tb/pp_spi_engine_bench.sv
module pp_spi_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic sclkEn = 1'b1;
  logic spiSclk, spiSsActive, irq;
  logic [3:0] spiSsIdx;
  logic [1:0] spiDout;
  logic [1:0] spiDin = 2'b00;

  int checks = 0;
  int failures = 0;
  int riseCnt = 0;
  int ssCnt = 0;
  int capPos = 0;
  int slvPos = 0;
  int divCnt = 0;
  bit dualMode = 0;
  bit slowEn = 0;
  logic [7:0] capData [8];
  logic [7:0] slvData [8];

  pp_spi_engine u_pp_spi_engine (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .sclkEn(sclkEn),
    .spiSclk(spiSclk), .spiSsActive(spiSsActive), .spiSsIdx(spiSsIdx),
    .spiDout(spiDout), .spiDin(spiDin), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    divCnt = (divCnt == 2) ? 0 : divCnt + 1;
    sclkEn = slowEn ? (divCnt == 0) : 1'b1;
  end

  always @(posedge spiSclk) begin
    #1;
    riseCnt++;
    if (capPos < 64) begin
      if (dualMode) begin
        capData[capPos/8][7 - capPos%8] = spiDout[1];
        capData[capPos/8][6 - capPos%8] = spiDout[0];
        capPos += 2;
      end else begin
        capData[capPos/8][7 - capPos%8] = spiDout[0];
        capPos += 1;
      end
    end
  end

  always @(posedge spiSsActive) ssCnt++;

  always @(posedge spiSsActive or negedge spiSclk) begin
    #1;
    if (spiSsActive && slvPos < 64) begin
      if (dualMode) begin
        spiDin = {slvData[slvPos/8][7 - slvPos%8], slvData[slvPos/8][6 - slvPos%8]};
        slvPos += 2;
      end else begin
        spiDin = {slvData[slvPos/8][7 - slvPos%8], 1'b0};
        slvPos += 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrBus(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdBus(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic wrBuf(input int idx, input logic [7:0] b);
    wrBus(11'h400 | 11'(idx), {24'h0, b});
  endtask

  task automatic setHdr(input logic [15:0] h);
    wrBuf(0, h[15:8]);
    wrBuf(1, h[7:0]);
  endtask

  task automatic prepMon(input bit dual);
    riseCnt = 0; ssCnt = 0; capPos = 0; slvPos = 0; dualMode = dual;
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin
      rdBus(11'd1, s);
      n++;
    end while (s[1] && n < 20000);
    if (s[1]) check({tag, " timeout"}, 1, 0);
  endtask

  task automatic clearInt();
    wrBus(11'd2, 32'h1f);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rdBus(11'd1, d); check("R1 status", d, 0);
    rdBus(11'd2, d); check("R1 raw", d, 0);
    check("R1 pins", {irq, spiSclk, spiSsActive}, 0);
  endtask

  task automatic t_write_slow();
    logic [31:0] d;
    wrBus(11'd3, 32'h1);
    setHdr(16'h4003);
    wrBuf(2, 8'hA5); wrBuf(3, 8'h3C); wrBuf(4, 8'hF0);
    prepMon(0); slowEn = 1;
    wrBus(11'd0, 32'h5001);
    rdBus(11'd1, d); check("R2 busy", d[1], 1);
    repeat (3) @(negedge clk);
    check("R2 frame", {spiSsActive, spiSsIdx}, {1'b1, 4'd5});
    waitIdle("R3");
    slowEn = 0;
    check("R3 byte0", capData[0], 8'hA5);
    check("R3 byte1", capData[1], 8'h3C);
    check("R3 byte2", capData[2], 8'hF0);
    check("R3 rises", riseCnt, 24);
    rdBus(11'd2, d); check("R7 raw done", d, 1);
    rdBus(11'd4, d); check("R7 masked", d, 1);
    check("R7 irq", irq, 1);
    wrBus(11'd2, 32'h1);
    rdBus(11'd2, d); check("R8 raw cleared", d, 0);
    check("R8 irq low", irq, 0);
  endtask

  task automatic t_read();
    logic [31:0] d;
    setHdr(16'h6002);
    slvData[0] = 8'h5A; slvData[1] = 8'hC3;
    prepMon(0);
    wrBus(11'd0, 32'h0001);
    waitIdle("R4");
    rdBus(11'h400, d); check("R4 rx0", d, 32'h5A);
    rdBus(11'h401, d); check("R4 rx1", d, 32'hC3);
    check("R4 rises", riseCnt, 16);
    clearInt();
  endtask

  task automatic t_xchg();
    logic [31:0] d;
    setHdr(16'h2002);
    wrBuf(2, 8'h81); wrBuf(3, 8'h7E);
    slvData[0] = 8'h3C; slvData[1] = 8'h99;
    prepMon(0);
    wrBus(11'd0, 32'h1001);
    waitIdle("R5");
    check("R5 tx0", capData[0], 8'h81);
    check("R5 tx1", capData[1], 8'h7E);
    rdBus(11'h400, d); check("R5 rx0", d, 32'h3C);
    rdBus(11'h401, d); check("R5 rx1", d, 32'h99);
    clearInt();
  endtask

  task automatic t_dual();
    logic [31:0] d;
    wrBus(11'd10, 32'h0005_0000);
    setHdr(16'h4802);
    wrBuf(2, 8'hB4); wrBuf(3, 8'h1E);
    prepMon(1);
    wrBus(11'd0, 32'h0201);
    waitIdle("R6");
    check("R6 dual tx0", capData[0], 8'hB4);
    check("R6 dual tx1", capData[1], 8'h1E);
    check("R6 dual rises", riseCnt, 8);
    setHdr(16'h6801);
    slvData[0] = 8'hD2;
    prepMon(1);
    wrBus(11'd0, 32'h0201);
    waitIdle("R6");
    rdBus(11'h400, d); check("R6 dual rx", d, 32'hD2);
    check("R6 dual rd rises", riseCnt, 4);
    setHdr(16'h4801);
    wrBuf(2, 8'h6B);
    prepMon(0);
    wrBus(11'd0, 32'h0001);
    waitIdle("R6");
    check("R6 profile0 single", riseCnt, 8);
    check("R6 profile0 data", capData[0], 8'h6B);
    clearInt();
  endtask

  task automatic t_bad();
    logic [31:0] d;
    logic [15:0] hdrs [3] = '{16'h4000, 16'h41FF, 16'hA001};
    for (int i = 0; i < 3; i++) begin
      setHdr(hdrs[i]);
      prepMon(0);
      wrBus(11'd0, 32'h0001);
      waitIdle("R9");
      rdBus(11'd2, d); check("R9 raw bad", d, 32'h11);
      check("R9 quiet", riseCnt + ssCnt, 0);
      clearInt();
    end
  endtask

  task automatic t_sleep_irq();
    logic [31:0] d;
    setHdr(16'h0004);
    prepMon(0);
    wrBus(11'd0, 32'h0001);
    waitIdle("R10");
    rdBus(11'd2, d); check("R10 sleep done", d, 1);
    check("R10 sleep quiet", riseCnt + ssCnt, 0);
    clearInt();
    wrBus(11'd3, 32'h0);
    setHdr(16'h8000);
    wrBus(11'd0, 32'h0001);
    waitIdle("R10");
    rdBus(11'd2, d); check("R10 setirq done", d, 1);
    rdBus(11'd4, d); check("R7 masked off", d, 0);
    check("R7 irq masked", irq, 0);
    clearInt();
    wrBus(11'd3, 32'h1);
  endtask

  task automatic t_halt();
    logic [31:0] d;
    setHdr(16'h4004);
    prepMon(0);
    wrBus(11'd0, 32'h0001);
    repeat (10) @(negedge clk);
    wrBus(11'd0, 32'h0003);
    check("R11 halt pins", {spiSsActive, spiSclk}, 0);
    rdBus(11'd1, d); check("R11 halt idle", d, 0);
    rdBus(11'd2, d); check("R11 no done", d, 0);
    setHdr(16'h4002);
    wrBuf(2, 8'h11); wrBuf(3, 8'h22);
    prepMon(0);
    wrBus(11'd0, 32'h3001);
    repeat (3) @(negedge clk);
    wrBus(11'd0, 32'h7001);
    check("R11 ss kept", spiSsIdx, 3);
    waitIdle("R11");
    check("R11 one frame", ssCnt, 1);
    check("R11 rises", riseCnt, 16);
    check("R11 data", capData[1], 8'h22);
    clearInt();
  endtask

  task automatic t_noop();
    logic [31:0] d;
    setHdr(16'h4001);
    prepMon(0);
    wrBus(11'd0, 32'h0000);
    wrBus(11'd0, 32'h0002);
    repeat (5) @(negedge clk);
    rdBus(11'd1, d); check("R12 idle", d, 0);
    rdBus(11'd2, d); check("R12 no int", d, 0);
    check("R12 quiet", riseCnt + ssCnt, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      capData[i] = '0;
      slvData[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_slow();
    t_read();
    t_xchg();
    t_dual();
    t_bad();
    t_sleep_irq();
    t_halt();
    t_noop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule